// File: doc/BRIEF.md
# Multi-channel chained DMA scheduler

This block holds the transfer contexts of twelve DMA channels and runs them through one shared transfer engine. A channel is loaded through a single scheduling port, either as a direct transfer (addresses, signed modifiers, a source word count) or as a chain kick that names a descriptor pointer. A loaded channel is busy and waits for a delay of a quarter of its word count in core cycles. It then becomes due. The engine moves its words over a single-cycle memory port, latches an interrupt and either frees the channel or reloads it from the next descriptor in memory.

The engine is a five-state machine. IDLE picks the lowest-numbered due channel. From IDLE it goes to FETCH for a kick, to FINISH for a zero-length transfer, and to READ otherwise. READ captures the source word and always goes to WRITE. WRITE stores the word, steps both addresses by their modifiers and returns to READ until the count is used up, then goes to FINISH. FINISH posts the interrupt and goes to FETCH when the chain pointer is non-zero, else to IDLE. FETCH reads seven descriptor words, installs the new context into the channel and returns to IDLE. The busy vector is readable at I/O address 0x37. A reset preloads a boot transfer on channel 6 that runs at once.

Top module: `dma_chain_sched`

## Requirements
- R1: Each of the 12 channels keeps its own context and busy bit. Reading I/O address 0x37 returns busy bit i for channel i in bit i, zero-extended. Any other I/O address reads 0.
- R2: An accepted schedule sets the channel's busy bit at the accepting edge. A transfer whose chain pointer is zero clears the bit at its completion edge.
- R3: With N = count/4 (integer) and t0 the accepting edge, and with the engine idle, word k is written in the cycle after edge t0+N+2+2k. Completion happens at edge t0+N+2+2C for C words.
- R4: Completion sets bit channel+10 of irq_latch. The same bit of irq_active is set only if irq_mask has that bit set. irq_ack clears the bits it names in both registers.
- R5: A schedule request for a busy channel or for a channel number of 12 or more is dropped. sched_err is high in the cycle after the request, and the channel context is left unchanged.
- R6: Each word moves from the source to the destination. After every word, both addresses advance by their own two's-complement modifier. Exactly count words move. A count of 0 moves nothing and still completes.
- R7: On completion with a non-zero chain pointer P, the engine reads P-1 (next pointer), P-2 (internal index), P-3 (internal modifier), P-4 (internal count), P-5 (external index), P-6 (external modifier) and P-7 (external count). The new context is installed 7 edges after completion, and that edge counts as its t0. Busy stays set throughout.
- R8: A chain with direction bit 1 (transmit) uses internal index, modifier and count as the source and the external index and modifier as the destination. Direction 0 (receive) swaps the roles, and the external count becomes the source count.
- R9: A direct schedule (sched_chain=0) stores a zero chain pointer. A kick (sched_chain=1) takes sched_src as the pointer, fetches at once without a delay and posts no interrupt. The installed transfer's t0 is 8 edges after the kick.
- R10: During reset, only channel 6 is busy, holding a boot transfer of 4 words from 512 to 640 with modifiers +1. It runs with no delay, with the edge before the first active edge as its t0.
- R11: When several channels are due in the same cycle, the lowest-numbered one is served first, and the others follow after it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_valid | input | 1 | Schedule request strobe |
| sched_chain | input | 1 | 1: chain kick, 0: direct transfer |
| sched_ch | input | 4 | Target channel |
| sched_src | input | 32 | Source address, or descriptor pointer for a kick |
| sched_dst | input | 32 | Destination address |
| sched_smod | input | 32 | Signed source modifier |
| sched_dmod | input | 32 | Signed destination modifier |
| sched_cnt | input | 16 | Source word count |
| sched_dir | input | 1 | Chain direction, 1 transmit, 0 receive |
| sched_err | output | 1 | Request rejected (one cycle) |
| irq_mask | input | 22 | Interrupt mask |
| irq_ack | input | 22 | Clear strobes for latch and active bits |
| irq_latch | output | 22 | Interrupt latch |
| irq_active | output | 22 | Masked active interrupts |
| io_addr | input | 8 | I/O register read address |
| io_rdata | output | 32 | I/O register read data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the same cycle |

## Verification
Every write is due in the cycle after edge t0+N+2+2k. The bench pushes each expected word with that cycle number into a scoreboard queue as soon as the scheduling edge is known. The monitor compares address, data and cycle on the falling edge. Busy drop and interrupt latching are due at edge t0+N+2+2C, and a chained install follows 7 edges later. For each of these, the bench waits for the cycle before the due edge and the due cycle itself and samples at the falling edge. Rejections are checked in the cycle right after the request, and the untouched context is shown by the original write stream.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int DESC_WORDS = 7;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] smod;
        logic [AW-1:0] dmod;
        logic [CW-1:0] scnt;
        logic [AW-1:0] chain;
        logic          dir;
        logic          kick;
    } dma_ctx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FINISH,
        ST_FETCH
    } eng_state_t;
endpackage

// File: rtl/dma_low_pick.sv
module dma_low_pick #(
    parameter int N = 12,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dma_delay_timer.sv
module dma_delay_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R3
    countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == CW'($past(cnt) - 1'b1)));

    // R3
    expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);
endmodule

// File: rtl/dma_chain_sched.sv
module dma_chain_sched
    import dma_sched_pkg::*;
#(
    parameter int NUM_CH      = 12,
    parameter int IRQ_BASE    = 10,
    parameter int IO_AW       = 8,
    parameter int STATUS_ADDR = 'h37,
    parameter int BOOT_CH     = 6,
    parameter int BOOT_SRC    = 512,
    parameter int BOOT_DST    = 640,
    parameter int BOOT_CNT    = 4,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IRQ_W = IRQ_BASE + NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sched_valid,
    input  logic             sched_chain,
    input  logic [CHW-1:0]   sched_ch,
    input  logic [AW-1:0]    sched_src,
    input  logic [AW-1:0]    sched_dst,
    input  logic [AW-1:0]    sched_smod,
    input  logic [AW-1:0]    sched_dmod,
    input  logic [CW-1:0]    sched_cnt,
    input  logic             sched_dir,
    output logic             sched_err,
    input  logic [IRQ_W-1:0] irq_mask,
    input  logic [IRQ_W-1:0] irq_ack,
    output logic [IRQ_W-1:0] irq_latch,
    output logic [IRQ_W-1:0] irq_active,
    input  logic [IO_AW-1:0] io_addr,
    output logic [AW-1:0]    io_rdata,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [AW-1:0]    mem_wdata,
    input  logic [AW-1:0]    mem_rdata
);
    eng_state_t state, nxt;
    dma_ctx_t   ctx [NUM_CH];
    dma_ctx_t   sched_ctx, boot_ctx, new_ctx;
    logic [NUM_CH-1:0] busy, t_exp, t_load, due;
    logic [CHW-1:0] cur, pick_idx;
    logic           pick_hit, acc, install;
    logic [AW-1:0]  w_src, w_dst, w_smod, w_dmod, w_chain, rd_buf;
    logic [CW-1:0]  w_cnt;
    logic           w_dir;
    logic [2:0]     fidx;
    logic [AW-1:0]  fw [DESC_WORDS-1];
    logic [IRQ_W-1:0] irq_set;

    assign acc = sched_valid && (int'(sched_ch) < NUM_CH) && !busy[sched_ch];
    assign due = (state == ST_IDLE) ? (busy & t_exp) : '0;

    dma_low_pick #(.N(NUM_CH)) u_pick (.req(due), .hit(pick_hit), .idx(pick_idx));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic          by_sched;
        logic [CW-1:0] tval;
        assign by_sched  = acc && (sched_ch == CHW'(g));
        assign t_load[g] = by_sched || (install && cur == CHW'(g));
        assign tval      = by_sched ? (sched_chain ? '0 : (sched_cnt >> 2)) : (new_ctx.scnt >> 2);
        dma_delay_timer #(.CW(CW)) u_tmr (
            .clk(clk), .rst_n(rst_n), .load(t_load[g]), .load_val(tval), .expired(t_exp[g])
        );
    end

    always_comb begin
        sched_ctx       = '0;
        sched_ctx.src   = sched_src;
        sched_ctx.dst   = sched_dst;
        sched_ctx.smod  = sched_smod;
        sched_ctx.dmod  = sched_dmod;
        sched_ctx.scnt  = sched_chain ? '0 : sched_cnt;
        sched_ctx.chain = sched_chain ? sched_src : '0;
        sched_ctx.dir   = sched_dir;
        sched_ctx.kick  = sched_chain;

        boot_ctx      = '0;
        boot_ctx.src  = AW'(BOOT_SRC);
        boot_ctx.dst  = AW'(BOOT_DST);
        boot_ctx.smod = AW'(1);
        boot_ctx.dmod = AW'(1);
        boot_ctx.scnt = CW'(BOOT_CNT);

        new_ctx       = '0;
        new_ctx.chain = fw[0];
        new_ctx.dir   = w_dir;
        if (w_dir) begin
            new_ctx.src = fw[1]; new_ctx.smod = fw[2]; new_ctx.scnt = fw[3][CW-1:0];
            new_ctx.dst = fw[4]; new_ctx.dmod = fw[5];
        end else begin
            new_ctx.src = fw[4]; new_ctx.smod = fw[5]; new_ctx.scnt = mem_rdata[CW-1:0];
            new_ctx.dst = fw[1]; new_ctx.dmod = fw[2];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and port outputs
    always_comb begin
        nxt       = state;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        install   = 1'b0;
        unique case (state)
            ST_IDLE: if (pick_hit) begin
                if (ctx[pick_idx].kick)              nxt = ST_FETCH;
                else if (ctx[pick_idx].scnt == '0)   nxt = ST_FINISH;
                else                                 nxt = ST_READ;
            end
            ST_READ: begin
                mem_rd = 1'b1; mem_addr = w_src; nxt = ST_WRITE;
            end
            ST_WRITE: begin
                mem_wr = 1'b1; mem_addr = w_dst; mem_wdata = rd_buf;
                nxt = (w_cnt == CW'(1)) ? ST_FINISH : ST_READ;
            end
            ST_FINISH: nxt = (w_chain != '0) ? ST_FETCH : ST_IDLE;
            ST_FETCH: begin
                mem_rd   = 1'b1;
                mem_addr = w_chain - AW'(fidx) - AW'(1);
                if (fidx == 3'(DESC_WORDS - 1)) begin
                    install = 1'b1; nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign irq_set  = (state == ST_FINISH) ? (IRQ_W'(1) << (IRQ_BASE + int'(cur))) : '0;
    assign io_rdata = (io_addr == IO_AW'(STATUS_ADDR)) ? AW'(busy) : '0;

    always_ff @(posedge clk) begin
        if (state == ST_FETCH && fidx != 3'(DESC_WORDS - 1)) fw[fidx] <= mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) ctx[i] <= (i == BOOT_CH) ? boot_ctx : '0;
            busy       <= NUM_CH'(1) << BOOT_CH;
            cur        <= '0;
            {w_src, w_dst, w_smod, w_dmod, w_chain, rd_buf} <= '0;
            w_cnt      <= '0;
            w_dir      <= 1'b0;
            fidx       <= '0;
            sched_err  <= 1'b0;
            irq_latch  <= '0;
            irq_active <= '0;
        end else begin
            sched_err  <= sched_valid && !acc;
            irq_latch  <= (irq_latch & ~irq_ack) | irq_set;
            irq_active <= (irq_active & ~irq_ack) | (irq_set & irq_mask);
            if (acc) begin
                ctx[sched_ch]  <= sched_ctx;
                busy[sched_ch] <= 1'b1;
            end
            unique case (state)
                ST_IDLE: if (pick_hit) begin
                    cur     <= pick_idx;
                    w_src   <= ctx[pick_idx].src;
                    w_dst   <= ctx[pick_idx].dst;
                    w_smod  <= ctx[pick_idx].smod;
                    w_dmod  <= ctx[pick_idx].dmod;
                    w_cnt   <= ctx[pick_idx].scnt;
                    w_chain <= ctx[pick_idx].chain;
                    w_dir   <= ctx[pick_idx].dir;
                    fidx    <= '0;
                end
                ST_READ: rd_buf <= mem_rdata;
                ST_WRITE: begin
                    w_src <= w_src + w_smod;
                    w_dst <= w_dst + w_dmod;
                    w_cnt <= w_cnt - 1'b1;
                end
                ST_FINISH: begin
                    fidx <= '0;
                    if (w_chain == '0) busy[cur] <= 1'b0;
                end
                ST_FETCH: begin
                    fidx <= fidx + 1'b1;
                    if (install) ctx[cur] <= new_ctx;
                end
                default: ;
            endcase
        end
    end

    // R5
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_valid && int'(sched_ch) < NUM_CH && busy[sched_ch]) |=> sched_err);

    // R2
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy[$past(sched_ch)]);

    // R4
    active_in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_active & ~irq_latch) == '0);

    // R7
    chain_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && w_chain != '0) |=> busy[$past(cur)]);

    // R6
    no_write_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !mem_wr);
endmodule

// File: tb/dma_chain_sched_test.sv
module dma_chain_sched_test;
    localparam int IRQW = 22;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, sched_valid, sched_chain, sched_dir, sched_err;
    logic [3:0]  sched_ch;
    logic [31:0] sched_src, sched_dst, sched_smod, sched_dmod;
    logic [15:0] sched_cnt;
    logic [IRQW-1:0] irq_mask, irq_ack, irq_latch, irq_active;
    logic [7:0]  io_addr;
    logic [31:0] io_rdata, mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr;

    dma_chain_sched uut (
        .clk(clk), .rst_n(rst_n), .sched_valid(sched_valid), .sched_chain(sched_chain),
        .sched_ch(sched_ch), .sched_src(sched_src), .sched_dst(sched_dst),
        .sched_smod(sched_smod), .sched_dmod(sched_dmod), .sched_cnt(sched_cnt),
        .sched_dir(sched_dir), .sched_err(sched_err), .irq_mask(irq_mask),
        .irq_ack(irq_ack), .irq_latch(irq_latch), .irq_active(irq_active),
        .io_addr(io_addr), .io_rdata(io_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int cyc = 0;
    int total = 0;
    int bad = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [31:0] mem [0:1023];
    logic        fill, poke_en;
    logic [9:0]  poke_a;
    logic [31:0] poke_d;

    function automatic logic [31:0] init_val(int a);
        return 32'h5A00_0000 | 32'(a);
    endfunction

    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < 1024; i++) mem[i] <= init_val(i);
        end else if (poke_en) mem[poke_a] <= poke_d;
        else if (mem_wr)      mem[mem_addr[9:0]] <= mem_wdata;
    end
    assign mem_rdata = mem[mem_addr[9:0]];

    typedef struct { int t; logic [31:0] a; logic [31:0] d; } wr_t;
    wr_t exp_q[$];

    task automatic push_xfer(int t1, int src, int smod, int dst, int dmod, int n);
        for (int k = 0; k < n; k++) begin
            wr_t e;
            e.t = t1 + 2 * k;
            e.a = 32'(dst + k * dmod);
            e.d = init_val(src + k * smod);
            exp_q.push_back(e);
        end
    endtask

    // monitor: pops the scoreboard on every write
    always @(negedge clk) begin
        wr_t e;
        if (rst_n && mem_wr) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R6 unexpected write addr=%0d data=%h at cycle %0d, expected none", mem_addr, mem_wdata, cyc);
            end else begin
                e = exp_q.pop_front();
                if (mem_addr !== e.a || mem_wdata !== e.d || cyc != e.t) begin
                    bad++;
                    $display("FAIL R3/R6 write got addr=%0d data=%h cyc=%0d expected addr=%0d data=%h cyc=%0d",
                             mem_addr, mem_wdata, cyc, e.a, e.d, e.t);
                end
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic sched(bit chain, int ch, int src, int smod, int dst, int dmod, int cnt, bit dir, output int t0);
        sched_valid = 1'b1; sched_chain = chain; sched_ch = 4'(ch);
        sched_src = 32'(src); sched_smod = 32'(smod); sched_dst = 32'(dst);
        sched_dmod = 32'(dmod); sched_cnt = 16'(cnt); sched_dir = dir;
        @(negedge clk);
        t0 = cyc;
        sched_valid = 1'b0; sched_chain = 1'b0;
    endtask

    task automatic poke(int a, int d);
        poke_en = 1'b1; poke_a = 10'(a); poke_d = 32'(d);
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic ack_all();
        irq_ack = '1;
        @(negedge clk);
        irq_ack = '0;
    endtask

    always @(posedge clk) begin
        if (cyc == 5000) begin
            total++; bad++;
            $display("FAIL watchdog expired, run hung (all R)");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t, t2, ta, tb;
        rst_n = 1'b0; fill = 1'b1; poke_en = 1'b0; poke_a = '0; poke_d = '0;
        sched_valid = 1'b0; sched_chain = 1'b0; sched_ch = '0; sched_src = '0; sched_dst = '0;
        sched_smod = '0; sched_dmod = '0; sched_cnt = '0; sched_dir = 1'b0;
        irq_mask = ~(IRQW'(1) << 12); irq_ack = '0; io_addr = 8'h37;
        repeat (3) @(negedge clk);
        check("R10 status in reset", io_rdata, 32'h40);
        check("R4 latch in reset", 32'(irq_latch), 32'h0);

        // R10 boot transfer on channel 6
        fill = 1'b0; rst_n = 1'b1;
        t = cyc;
        push_xfer(t + 2, 512, 1, 640, 1, 4);
        wait_until(t + 9);
        check("R10 boot busy before completion", io_rdata, 32'h40);
        wait_until(t + 10);
        check("R2 boot busy cleared", io_rdata, 32'h0);
        check("R4 boot latch bit16", 32'(irq_latch), 32'h1_0000);
        check("R4 boot active bit16", 32'(irq_active), 32'h1_0000);
        ack_all();
        check("R4 ack clears latch", 32'(irq_latch), 32'h0);

        // R3 delay, masked interrupt on channel 2
        sched(1'b0, 2, 10, 1, 700, 1, 4, 1'b0, t);
        push_xfer(t + 3, 10, 1, 700, 1, 4);
        wait_until(t + 10);
        check("R3 ch2 still busy", io_rdata, 32'h4);
        wait_until(t + 11);
        check("R2 ch2 busy cleared", io_rdata, 32'h0);
        check("R4 ch2 latch bit12", 32'(irq_latch), 32'h1000);
        check("R4 ch2 masked active", 32'(irq_active), 32'h0);
        ack_all();

        // R6 negative modifiers on channel 0
        sched(1'b0, 0, 50, -2, 760, -1, 3, 1'b0, t);
        push_xfer(t + 2, 50, -2, 760, -1, 3);
        wait_until(t + 8);
        check("R6 ch0 done", io_rdata, 32'h0);
        check("R4 ch0 active bit10", 32'(irq_active), 32'h400);
        ack_all();

        // R6 zero count on channel 4
        sched(1'b0, 4, 20, 1, 720, 1, 0, 1'b0, t);
        check("R2 ch4 busy set", io_rdata, 32'h10);
        wait_until(t + 2);
        check("R6 zero count completes", io_rdata, 32'h0);
        check("R6 zero count latch bit14", 32'(irq_latch), 32'h4000);
        ack_all();

        // R5 rejection
        sched(1'b0, 7, 80, 1, 800, 1, 40, 1'b0, t);
        check("R5 first request accepted", 32'(sched_err), 32'h0);
        push_xfer(t + 12, 80, 1, 800, 1, 40);
        sched(1'b0, 7, 200, 1, 900, 1, 4, 1'b0, t2);
        check("R5 busy channel rejected", 32'(sched_err), 32'h1);
        sched(1'b0, 13, 200, 1, 900, 1, 4, 1'b0, t2);
        check("R5 channel 13 rejected", 32'(sched_err), 32'h1);
        sched(1'b0, 8, 0, 1, 0, 1, 0, 1'b0, t2);
        check("R5 free channel accepted", 32'(sched_err), 32'h0);
        io_addr = 8'h36;
        #1 check("R1 other address reads zero", io_rdata, 32'h0);
        io_addr = 8'h37;
        #1 check("R1 status shows ch7 and ch8", io_rdata, 32'h180);
        wait_until(t + 92);
        check("R5 ch7 completed with original context", io_rdata, 32'h0);
        check("R4 latch bits 17 and 18", 32'(irq_latch), 32'h6_0000);
        ack_all();

        // R11 two channels due together
        sched(1'b0, 5, 150, 1, 330, 1, 8, 1'b0, t);
        sched(1'b0, 2, 170, 1, 350, 1, 4, 1'b0, t2);
        push_xfer(t + 4, 170, 1, 350, 1, 4);
        push_xfer(t + 14, 150, 1, 330, 1, 8);
        wait_until(t + 12);
        check("R11 ch2 served first", io_rdata, 32'h20);
        wait_until(t + 30);
        check("R11 ch5 served after", io_rdata, 32'h0);
        ack_all();

        // R7 R8 R9 transmit chain on channel 3
        poke(899, 920); poke(898, 100); poke(897, 1); poke(896, 4);
        poke(895, 300); poke(894, 2); poke(893, 99);
        poke(919, 0); poke(918, 120); poke(917, -1); poke(916, 2);
        poke(915, 400); poke(914, 1); poke(913, 5);
        sched(1'b1, 3, 900, 0, 0, 0, 0, 1'b1, t);
        ta = t + 8;
        tb = ta + 18;
        push_xfer(ta + 3, 100, 1, 300, 2, 4);
        push_xfer(tb + 2, 120, -1, 400, 1, 2);
        wait_until(ta);
        check("R9 kick posts no interrupt", 32'(irq_latch), 32'h0);
        check("R9 kick keeps busy", io_rdata, 32'h8);
        wait_until(ta + 11);
        check("R7 first link latch bit13", 32'(irq_latch), 32'h2000);
        check("R7 busy kept across reload", io_rdata, 32'h8);
        wait_until(tb + 5);
        check("R7 second link running", io_rdata, 32'h8);
        wait_until(tb + 6);
        check("R7 chain end clears busy", io_rdata, 32'h0);
        ack_all();

        // R8 receive chain on channel 1
        poke(959, 0); poke(958, 600); poke(957, 1); poke(956, 77);
        poke(955, 500); poke(954, 1); poke(953, 3);
        sched(1'b1, 1, 960, 0, 0, 0, 0, 1'b0, t);
        push_xfer(t + 10, 500, 1, 600, 1, 3);
        wait_until(t + 15);
        check("R8 receive still busy", io_rdata, 32'h2);
        wait_until(t + 16);
        check("R8 receive done", io_rdata, 32'h0);
        check("R8 receive latch bit11", 32'(irq_latch), 32'h800);

        repeat (5) @(negedge clk);
        check("R6 all expected writes seen", 32'(exp_q.size()), 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule